// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block drives an asynchronous serial line from characters that a host writes into it. Each character leaves as one frame: a low start bit, 5 to 8 data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. The line stays high between frames. The frame shape is chosen at run time through a small set of line-control inputs. Each frame latches those inputs when it starts, so software must only change them while the block is quiet.

Characters wait in a holding queue. With queueing switched on, the queue holds 16 entries. With it switched off, the queue shrinks to one holding slot, so each character goes out on its own and the full flag rises after a single write. Sending only starts when both the global enable and the transmit enable are high. A 16x baud tick paces every bit.

The sequencer has five states. IDLE moves to START when both enables are high and the queue is not empty, and that move pops one character. START moves to DATA after 16 ticks. DATA moves to PARITY after the last data bit if parity is on, and otherwise to STOP. PARITY moves to STOP after 16 ticks. STOP returns to IDLE after the last stop bit. In every other case each state holds.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0, `fifo_empty` is 1 and `fifo_full` is 0; while no frame is under way `txd` is 1.
- R2: A frame starts with one start bit at 0 and then the data bits, least significant first. Every bit lasts 16 cycles in which `baud_tick` is high.
- R3: `wlen` sets the number of data bits as `wlen`+5: 2'b00 gives 5 bits and 2'b11 gives 8 bits. Higher character bits are not sent.
- R4: When `par_en` is 1, one parity bit follows the data. With `par_even`=1 the parity bit makes the count of ones in data plus parity even. With `par_even`=0 it makes that count odd. When `par_en` is 0, no parity bit is sent.
- R5: The frame ends with one stop bit at 1 when `two_stop`=0 and with two stop bits when `two_stop`=1.
- R6: With `fifo_on`=1 the queue holds 16 characters and sends them in write order. `fifo_full` is 1 exactly when 16 are held, and `fifo_empty` is 1 exactly when none are held.
- R7: With `fifo_on`=0 the queue holds one character, and `fifo_full` rises after a single write.
- R8: A write while `fifo_full` is 1 is dropped, and that character is never sent.
- R9: No frame starts unless both `glb_en` and `tx_en` are 1. Queued characters wait and `txd` stays 1.
- R10: `busy` is 1 while any character is queued or a frame is under way. It falls in the cycle after the last stop bit ends if nothing else is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to queue |
| wlen | input | 2 | Data length minus five |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | 1 selects even parity, 0 selects odd |
| two_stop | input | 1 | 1 selects two stop bits |
| fifo_on | input | 1 | 1 selects the 16-entry queue, 0 the single slot |
| glb_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit enable |
| baud_tick | input | 1 | Pulse at 16 times the bit rate |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Character queued or frame under way |
| fifo_full | output | 1 | Queue cannot take another character |
| fifo_empty | output | 1 | Queue holds no character |

## Verification
The checker tests four rules on every cycle. The full and empty flags are never high together. The line is high whenever the sequencer is idle. The sequencer stays idle while either enable is low. A full 16-entry queue stays full under writes while sending is blocked. The same checker also ties `busy` to a non-empty queue. Bit values, parity polarity, stop-bit count, the time `busy` falls and the dropping of extra writes show only in the bench scenarios. There a monitor decodes each frame against the expected character and line settings queued by the driver.

// File: rtl/uartx_pkg.sv
package uartx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    // Keep only the bits that the selected word length sends.
    function automatic logic [7:0] keep_bits(input logic [7:0] d, input logic [1:0] wl);
        return d & (8'hFF >> (2'd3 - wl));
    endfunction
endpackage

// File: rtl/uartx_queue.sv
module uartx_queue #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          deep_mode,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count, cap;
    logic          push;

    assign cap   = deep_mode ? CW'(DEPTH) : CW'(1);
    assign full  = (count >= cap);
    assign empty = (count == '0);
    assign push  = push_req && !full;
    assign head  = mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end
endmodule

// File: rtl/uartx_framer.sv
module uartx_framer
    import uartx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       tick,
    input  logic       q_empty,
    input  logic [7:0] q_head,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       two_stop,
    output logic       pop,
    output logic       txd,
    output logic       idle
);
    tx_state_t  state_q, state_d;
    logic [3:0] tick_q;
    logic [2:0] bit_q;
    logic       stop_q;
    logic [7:0] sh_q;
    logic       par_q, pen_q, two_q;
    logic [1:0] wl_q;
    logic       bit_end, last_data, last_stop, start_ok;
    logic [7:0] kept;

    assign bit_end   = tick && (tick_q == 4'd15);
    assign last_data = (bit_q == (3'd4 + {1'b0, wl_q}));
    assign last_stop = (stop_q == two_q);
    assign start_ok  = go && !q_empty;
    assign kept      = keep_bits(q_head, wlen);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_ok) state_d = ST_START;
            ST_START:  if (bit_end) state_d = ST_DATA;
            ST_DATA:   if (bit_end && last_data) state_d = pen_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_d = ST_STOP;
            ST_STOP:   if (bit_end && last_stop) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tick_q  <= '0;
            bit_q   <= '0;
            stop_q  <= 1'b0;
            sh_q    <= '0;
            par_q   <= 1'b0;
            pen_q   <= 1'b0;
            two_q   <= 1'b0;
            wl_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) tick_q <= '0;
            else if (tick && state_q != ST_IDLE) tick_q <= tick_q + 1'b1;
            if (state_q == ST_IDLE && start_ok) begin
                sh_q  <= kept;
                par_q <= par_even ? ^kept : ~^kept;
                pen_q <= par_en;
                two_q <= two_stop;
                wl_q  <= wlen;
                bit_q <= '0;
            end else if (state_q == ST_DATA && bit_end) begin
                sh_q  <= sh_q >> 1;
                bit_q <= bit_q + 1'b1;
            end
            if (state_q != ST_STOP) stop_q <= 1'b0;
            else if (bit_end) stop_q <= 1'b1;
        end
    end

    always_comb begin
        pop  = (state_q == ST_IDLE) && start_ok;
        idle = (state_q == ST_IDLE);
        unique case (state_q)
            ST_IDLE:   txd = 1'b1;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = sh_q[0];
            ST_PARITY: txd = par_q;
            ST_STOP:   txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
    parameter int QDEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       two_stop,
    input  logic       fifo_on,
    input  logic       glb_en,
    input  logic       tx_en,
    input  logic       baud_tick,
    output logic       txd,
    output logic       busy,
    output logic       fifo_full,
    output logic       fifo_empty
);
    logic [7:0] q_head;
    logic       q_pop, line_idle;

    uartx_queue #(.DEPTH(QDEPTH), .DW(8)) u_queue (
        .clk(clk), .rst_n(rst_n), .deep_mode(fifo_on),
        .push_req(wr_valid), .push_data(wr_data), .pop(q_pop),
        .head(q_head), .full(fifo_full), .empty(fifo_empty)
    );

    uartx_framer u_framer (
        .clk(clk), .rst_n(rst_n), .go(glb_en && tx_en), .tick(baud_tick),
        .q_empty(fifo_empty), .q_head(q_head), .wlen(wlen), .par_en(par_en),
        .par_even(par_even), .two_stop(two_stop), .pop(q_pop), .txd(txd),
        .idle(line_idle)
    );

    assign busy = !fifo_empty || !line_idle;
endmodule

// File: rtl/uartx_tx_checker.sv
module uartx_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic fifo_on,
    input logic glb_en,
    input logic tx_en,
    input logic txd,
    input logic busy,
    input logic fifo_full,
    input logic fifo_empty,
    input logic line_idle
);
    p_flags_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    p_idle_line_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        line_idle |-> txd);

    p_hold_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_idle && !(glb_en && tx_en)) |=> line_idle);

    p_drop_keeps_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && fifo_on && wr_valid && !(glb_en && tx_en)) |=> fifo_full);

    p_busy_when_queued_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_empty |-> busy);
endmodule

bind uart_frame_tx uartx_tx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .fifo_on(fifo_on),
    .glb_en(glb_en), .tx_en(tx_en), .txd(txd), .busy(busy),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .line_idle(line_idle)
);

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] wlen = 2'b11;
    logic       par_en = 1'b0, par_even = 1'b0, two_stop = 1'b0, fifo_on = 1'b0;
    logic       glb_en = 1'b1, tx_en = 1'b1, baud_tick = 1'b1;
    logic       txd, busy, fifo_full, fifo_empty;

    int checks = 0;
    int errors = 0;
    logic [15:0] expq[$];

    uart_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wlen(wlen), .par_en(par_en), .par_even(par_even), .two_stop(two_stop),
        .fifo_on(fifo_on), .glb_en(glb_en), .tx_en(tx_en), .baud_tick(baud_tick),
        .txd(txd), .busy(busy), .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cfg();
        return {1'b0, wlen, fifo_on, two_stop, par_even, par_en, 1'b0};
    endfunction

    // Driver: write one character and record what must appear on the line.
    task automatic send(input logic [7:0] d, input bit expect_out);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        if (expect_out) expq.push_back({cfg(), d});
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0 || busy) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    // Monitor: decode each frame against the oldest expected item.
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (txd === 1'b0) begin
                logic [15:0] it;
                int len, nstop;
                logic acc;
                if (expq.size() == 0) begin
                    chk(1'b0, "R8 unexpected frame", 1, 0);
                    it = 16'h0;
                end else begin
                    it = expq.pop_front();
                end
                len   = int'(it[14:13]) + 5;
                nstop = it[11] ? 2 : 1;
                acc   = 1'b0;
                repeat (8) @(negedge clk);
                chk(txd == 1'b0, "R2 start bit", txd, 0);
                for (int i = 0; i < len; i++) begin
                    repeat (16) @(negedge clk);
                    chk(txd == it[i], "R2 R3 data bit", txd, it[i]);
                    acc ^= it[i];
                end
                if (it[9]) begin
                    repeat (16) @(negedge clk);
                    chk(txd == (it[10] ? acc : ~acc), "R4 parity bit", txd, it[10] ? acc : ~acc);
                end
                for (int s = 0; s < nstop; s++) begin
                    repeat (16) @(negedge clk);
                    chk(txd == 1'b1, "R5 stop bit", txd, 1);
                end
                repeat (7) @(negedge clk);
                chk(busy == 1'b1, "R10 busy in last stop cycle", busy, 1);
                @(negedge clk);
                chk(txd == 1'b1, "R1 line high after frame", txd, 1);
                if (expq.size() == 0)
                    chk(busy == 1'b0, "R10 busy falls after last stop", busy, 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1 reset txd", txd, 1);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        chk(fifo_empty == 1'b1, "R1 reset empty", fifo_empty, 1);
        chk(fifo_full == 1'b0, "R1 reset full", fifo_full, 0);

        // R2 R3: eight data bits, no parity, one stop, single slot
        send(8'hA5, 1'b1);
        drain();
        // R3 R4: five bits (upper bits dropped), even parity
        wlen = 2'b00; par_en = 1'b1; par_even = 1'b1;
        send(8'hF3, 1'b1);
        drain();
        // R4 R5: seven bits, odd parity, two stops
        wlen = 2'b10; par_even = 1'b0; two_stop = 1'b1;
        send(8'h5A, 1'b1);
        drain();
        // R6: queue order, six bits, no parity, two stops
        wlen = 2'b01; par_en = 1'b0; fifo_on = 1'b1;
        send(8'h01, 1'b1); send(8'h2E, 1'b1); send(8'h15, 1'b1);
        send(8'h3F, 1'b1); send(8'h00, 1'b1);
        drain();

        // R9: global enable low holds the character
        wlen = 2'b11; two_stop = 1'b0; par_en = 1'b1; par_even = 1'b1;
        glb_en = 1'b0;
        send(8'hC3, 1'b1);
        begin
            bit quiet = 1'b1;
            repeat (60) begin @(negedge clk); if (txd !== 1'b1) quiet = 1'b0; end
            chk(quiet, "R9 line idle while global enable low", 0, 1);
        end
        chk(fifo_empty == 1'b0, "R9 character held", fifo_empty, 0);
        chk(busy == 1'b1, "R10 busy while character queued", busy, 1);
        glb_en = 1'b1;
        drain();
        // R9: transmit enable low holds the character
        tx_en = 1'b0;
        send(8'h7E, 1'b1);
        begin
            bit quiet = 1'b1;
            repeat (60) begin @(negedge clk); if (txd !== 1'b1) quiet = 1'b0; end
            chk(quiet, "R9 line idle while transmit enable low", 0, 1);
        end
        tx_en = 1'b1;
        drain();

        // R6 R8: fill 16 entries, then a dropped write
        tx_en = 1'b0; par_en = 1'b0;
        for (int k = 0; k < 16; k++) begin
            send(8'(k * 13 + 7), 1'b1);
            if (k == 14) chk(fifo_full == 1'b0, "R6 not full at 15", fifo_full, 0);
        end
        chk(fifo_full == 1'b1, "R6 full at 16", fifo_full, 1);
        send(8'hEE, 1'b0);
        chk(fifo_full == 1'b1, "R8 still full after dropped write", fifo_full, 1);
        tx_en = 1'b1;
        drain();

        // R7 R8: single slot fills after one write
        tx_en = 1'b0; fifo_on = 1'b0;
        send(8'h96, 1'b1);
        chk(fifo_full == 1'b1, "R7 single slot full", fifo_full, 1);
        send(8'h69, 1'b0);
        tx_en = 1'b1;
        drain();

        chk(expq.size() == 0, "R8 all expected frames seen", expq.size(), 0);
        chk(fifo_empty == 1'b1 && busy == 1'b0, "R10 quiet at end", busy, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule